// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one serial-flash command for each write to its command register. It puts a command on an SPI mode 3 half-duplex link. A command consists of an opcode byte, up to three address bytes, up to fifteen dummy byte times and up to four data bytes. The data bytes are either sent from the data register or received into it. The command word carries the opcode, the direction, the data count, the address count, the dummy count, a chip-select index and a keep-selected flag. Software builds a flash transaction longer than four bytes by chaining commands with that flag set.

The block does not generate SCK timing itself. A separate timing block pulses `sck_tick`, and each pulse moves the serial clock by one half period. While SCK is high a pulse makes a falling edge, and the next data bit is launched on it. While SCK is low a pulse makes a rising edge, and MISO is sampled on it. After the last bit of a command, one more pulse closes the command. On that closing pulse the chip select is released or kept, and pending clears.

Software reaches the block through a word-indexed register bus. Index 0 is the command register; a write there starts a command, and a read returns the last accepted command. Index 1 holds the address in bits 23:0. Index 2 is the data register. Index 3 is status: bit 22 is pending and bit 29 is the sticky error flag. Writes to the address and data registers are ignored while a command is pending.

Top module: `sflash_seq`

## Requirements
- R1: The command word fields are: opcode in 7:0, write in bit 8, data count in 11:9, keep-selected in bit 15, dummy count in 19:16, address count in 22:20, chip-select index in 26:24. On a fresh transaction the opcode byte is sent first. Every byte goes out most significant bit first. MOSI changes on falling SCK edges, and SCK idles high whenever no command is pending.
- R2: The address phase follows the opcode. It sends the low N bytes of the address register, highest of those first, where N is the address count. A count field above 3 is treated as 3.
- R3: The dummy phase follows the address phase and lasts the dummy count in byte times (0 to 15). MOSI is low throughout it.
- R4: For a write, the data phase sends N bytes of the data register little-endian: bits 7:0 go out first. A data count field above 4 is treated as 4.
- R5: For a read, N bytes are sampled on rising SCK edges and stored little-endian in the data register. Bytes at and above N keep their value, and MOSI stays low during the data phase.
- R6: The pending bit (status bit 22) reads 1 in the cycle after an accepted command write. It reads 0 once the command has closed.
- R7: A command write while pending sets the error bit (status bit 29), and that command is discarded: nothing of it reaches the wire. Writing 1 to status bit 29 clears the error bit.
- R8: With keep-selected set, the chip select stays low after the command. While it is held, the next command sends no opcode, and that command's chip-select index is ignored.
- R9: With keep-selected clear, the chip select is released when the command closes. A command with zero address, dummy and data counts sent while the chip select is held puts no SCK edges on the wire and only ends the transaction.
- R10: After reset, SCK is high, every chip select is high, MOSI is low and status is 0. At most one chip select is low at any time, and SCK changes only in a cycle where `sck_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register index (0 command, 1 address, 2 data, 3 status) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_sel` |
| sck_tick | input | 1 | Half-period step pulse from the timing block |
| sck | output | 1 | Serial clock, idles high |
| cs_n | output | 2**CS_W | Active-low chip selects, one per index |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench runs a fixed-seed random mix of commands while `sck_tick` arrives with random gaps. The commands vary in direction, address count, dummy count, data count, chip select and keep flag, so the order of the phases and the placement of bytes are tried in many combinations. A bench model of the flash serves as the MISO source, and its byte pattern depends on the byte position. A read that lands bytes in the wrong lane or with a wrong bit alignment therefore shows up in the data register. Directed cases cover the things random mixes hit rarely: a chained transaction across two chip-select indices, an end-only command, out-of-range address and data counts, a partial read that must leave the upper bytes untouched, and a command issued while pending. Each case tells apart opcode skipping, clamping, byte-lane masking and rejection.

// File: rtl/sflash_seq.sv
module sflash_seq #(
  parameter int CS_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_we,
  input  logic [1:0]              bus_sel,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic                    sck_tick,
  output logic                    sck,
  output logic [(1<<CS_W)-1:0]    cs_n,
  output logic                    mosi,
  input  logic                    miso
);
  localparam int NCS = 1 << CS_W;
  localparam logic [2:0] PH_OPC = 3'd0, PH_ADR = 3'd1, PH_DUM = 3'd2,
                         PH_DAT = 3'd3, PH_END = 3'd4;

  function automatic logic [2:0] first_ph(input logic [2:0] s, input logic [1:0] a,
                                          input logic [3:0] d, input logic [2:0] n);
    if (s == PH_OPC) return PH_OPC;
    if (s <= PH_ADR && a != 2'd0) return PH_ADR;
    if (s <= PH_DUM && d != 4'd0) return PH_DUM;
    if (s <= PH_DAT && n != 3'd0) return PH_DAT;
    return PH_END;
  endfunction

  function automatic logic [3:0] len_of(input logic [2:0] p, input logic [1:0] a,
                                        input logic [3:0] d, input logic [2:0] n);
    case (p)
      PH_OPC:  return 4'd1;
      PH_ADR:  return {2'b00, a};
      PH_DUM:  return d;
      PH_DAT:  return {1'b0, n};
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [7:0] byte_of(input logic [2:0] p, input logic [3:0] lf,
                                         input logic [7:0] op, input logic [23:0] ad,
                                         input logic [31:0] dt, input logic [2:0] n,
                                         input logic w);
    logic [23:0] ta;
    logic [31:0] td;
    logic [3:0]  k;
    ta = ad >> {lf - 4'd1, 3'b000};
    k  = {1'b0, n} - lf;
    td = dt >> {k[1:0], 3'b000};
    case (p)
      PH_OPC:  return op;
      PH_ADR:  return ta[7:0];
      PH_DAT:  return w ? td[7:0] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  logic            busy, err, held, wr_q, keep_q, sck_q, mosi_q;
  logic [CS_W-1:0] csel;
  logic [7:0]      opc_q, sh;
  logic [1:0]      al_q;
  logic [3:0]      dm_q, left;
  logic [2:0]      dl_q, ph, bitn;
  logic [23:0]     addr_q;
  logic [31:0]     data_q, cmd_q;

  wire        cmd_wr = bus_we && bus_sel == 2'd0;
  wire [2:0]  al_f   = bus_wdata[22:20];
  wire [2:0]  dl_f   = bus_wdata[11:9];
  wire [1:0]  al_c   = (al_f > 3'd3) ? 2'd3 : al_f[1:0];
  wire [2:0]  dl_c   = (dl_f > 3'd4) ? 3'd4 : dl_f;
  wire [3:0]  dm_w   = bus_wdata[19:16];
  wire [2:0]  p0     = first_ph(held ? PH_ADR : PH_OPC, al_c, dm_w, dl_c);
  wire [3:0]  l0     = len_of(p0, al_c, dm_w, dl_c);

  wire        rx_dat = ph == PH_DAT && !wr_q;
  wire [7:0]  sh_in  = {sh[6:0], miso};
  wire [3:0]  didx   = {1'b0, dl_q} - left;
  wire [2:0]  pn     = first_ph(ph + 3'd1, al_q, dm_q, dl_q);
  wire [3:0]  ln     = len_of(pn, al_q, dm_q, dl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; err <= 1'b0; held <= 1'b0; wr_q <= 1'b0; keep_q <= 1'b0;
      sck_q <= 1'b1; mosi_q <= 1'b0; csel <= '0; opc_q <= '0; sh <= '0;
      al_q <= '0; dm_q <= '0; left <= '0; dl_q <= '0; ph <= PH_END; bitn <= '0;
      addr_q <= '0; data_q <= '0; cmd_q <= '0;
    end else begin
      if (bus_we && bus_sel == 2'd3 && bus_wdata[29]) err <= 1'b0;
      if (!busy && bus_we && bus_sel == 2'd1) addr_q <= bus_wdata[23:0];
      if (!busy && bus_we && bus_sel == 2'd2) data_q <= bus_wdata;
      if (cmd_wr && busy) err <= 1'b1;
      if (cmd_wr && !busy) begin
        busy   <= 1'b1;
        held   <= 1'b1;
        if (!held) csel <= bus_wdata[24 +: CS_W];
        cmd_q  <= bus_wdata;
        opc_q  <= bus_wdata[7:0];
        wr_q   <= bus_wdata[8];
        keep_q <= bus_wdata[15];
        al_q   <= al_c;
        dm_q   <= dm_w;
        dl_q   <= dl_c;
        ph     <= p0;
        left   <= l0;
        bitn   <= '0;
        sh     <= byte_of(p0, l0, bus_wdata[7:0], addr_q, data_q, dl_c, bus_wdata[8]);
      end else if (busy && sck_tick) begin
        if (ph == PH_END) begin
          busy   <= 1'b0;
          held   <= keep_q;
          mosi_q <= 1'b0;
        end else if (sck_q) begin
          sck_q  <= 1'b0;
          mosi_q <= rx_dat ? 1'b0 : sh[7];
        end else begin
          sck_q <= 1'b1;
          bitn  <= bitn + 3'd1;
          if (bitn == 3'd7) begin
            if (rx_dat) data_q[{didx[1:0], 3'b000} +: 8] <= sh_in;
            if (left == 4'd1) begin
              ph   <= pn;
              left <= ln;
              sh   <= byte_of(pn, ln, opc_q, addr_q, data_q, dl_q, wr_q);
            end else begin
              left <= left - 4'd1;
              sh   <= byte_of(ph, left - 4'd1, opc_q, addr_q, data_q, dl_q, wr_q);
            end
          end else begin
            sh <= sh_in;
          end
        end
      end
    end
  end

  assign sck  = sck_q;
  assign mosi = mosi_q;
  assign cs_n = held ? ~(NCS'(1) << csel) : '1;

  always_comb begin
    case (bus_sel)
      2'd0:    bus_rdata = cmd_q;
      2'd1:    bus_rdata = {8'h00, addr_q};
      2'd2:    bus_rdata = data_q;
      default: bus_rdata = {2'b00, err, 6'b0, busy, 22'b0};
    endcase
  end
endmodule

// File: rtl/sflash_seq_chk.sv
module sflash_seq_chk #(
  parameter int CS_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_we,
  input logic [1:0]           bus_sel,
  input logic                 sck_tick,
  input logic                 sck,
  input logic [(1<<CS_W)-1:0] cs_n,
  input logic                 busy,
  input logic                 err
);
  p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sck);
  p_pend_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_sel == 2'd0 && !busy) |=> busy);
  p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_sel == 2'd0 && busy) |=> err);
  p_sck_low_cs_r8: assert property (@(posedge clk) disable iff (!rst_n) !sck |-> !(&cs_n));
  p_cs_single_r10: assert property (@(posedge clk) disable iff (!rst_n) $countones(~cs_n) <= 1);
  p_sck_tick_r10: assert property (@(posedge clk) disable iff (!rst_n) !sck_tick |=> $stable(sck));
endmodule

bind sflash_seq sflash_seq_chk #(.CS_W(CS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel), .sck_tick(sck_tick),
  .sck(sck), .cs_n(cs_n), .busy(busy), .err(err)
);

// File: tb/sflash_seq_bench.sv
module sflash_seq_bench;
  logic        clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, sck_tick = 1'b0, miso = 1'b0;
  logic [1:0]  bus_sel = 2'd0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        sck, mosi;
  logic [7:0]  cs_n;

  sflash_seq u_sflash_seq (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_tick(sck_tick), .sck(sck),
    .cs_n(cs_n), .mosi(mosi), .miso(miso));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, nrise = 0, nfall = 0, ne = 0, badcs = 0, start = 0;
  logic [7:0]  cap [0:4095];
  logic [7:0]  expb[0:4095];
  logic [7:0]  rsh = '0;
  logic [7:0]  exp_cs = 8'hFF;
  logic        held = 1'b0, tick_on = 1'b1;
  logic [2:0]  cur_cs = '0;
  logic [31:0] exp_dat = '0;
  logic        exp_rd = 1'b0;

  function automatic logic [7:0] patb(input int k);
    logic [31:0] v;
    v = k * 32'd59 + 32'd90;
    return v[7:0];
  endfunction

  function automatic logic [31:0] mk(input logic [7:0] op, input logic w, input logic [2:0] dl,
                                     input logic kp, input logic [3:0] dm,
                                     input logic [2:0] al, input logic [2:0] cs);
    return {5'b0, cs, 1'b0, al, dm, kp, 3'b0, dl, w, op};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) sck_tick <= tick_on && ($urandom % 2 == 0);

  always @(posedge sck) if (rst_n) begin
    rsh = {rsh[6:0], mosi};
    nrise++;
    if (nrise % 8 == 0) cap[nrise/8 - 1] = rsh;
    if (cs_n !== exp_cs) badcs++;
  end

  always @(negedge sck) if (rst_n) begin
    logic [7:0] b;
    b = patb(nfall / 8);
    miso = b[7 - (nfall % 8)];
    nfall++;
  end

  task automatic wreg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] s, output logic [31:0] d);
    bus_sel = s;
    #1;
    d = bus_rdata;
  endtask

  task automatic issue(input logic [7:0] op, input logic w, input logic [2:0] dl, input logic kp,
                       input logic [3:0] dm, input logic [2:0] al, input logic [2:0] cs,
                       input logic [23:0] ad, input logic [31:0] dt);
    int alc, dlc;
    logic [31:0] st;
    alc = (al > 3) ? 3 : int'(al);
    dlc = (dl > 4) ? 4 : int'(dl);
    wreg(2'd1, {8'h00, ad});
    wreg(2'd2, dt);
    start = ne;
    exp_dat = dt;
    exp_rd = !w && dlc > 0;
    if (!held) begin
      cur_cs = cs;
      expb[ne] = op; ne++;
    end
    exp_cs = ~(8'd1 << cur_cs);
    for (int i = alc; i >= 1; i--) begin
      expb[ne] = ad[8*(i-1) +: 8]; ne++;
    end
    for (int i = 0; i < int'(dm); i++) begin
      expb[ne] = 8'h00; ne++;
    end
    for (int j = 0; j < dlc; j++) begin
      if (w) expb[ne] = dt[8*j +: 8];
      else begin
        expb[ne] = 8'h00;
        exp_dat[8*j +: 8] = patb(ne);
      end
      ne++;
    end
    held = kp;
    wreg(2'd0, mk(op, w, dl, kp, dm, al, cs));
    rreg(2'd3, st);
    chk(st[22] === 1'b1, "R6 pending after command write", st, 32'h0040_0000);
  endtask

  task automatic finish_cmd(input string tag);
    logic [31:0] st, dv;
    logic ok;
    rreg(2'd3, st);
    while (st[22]) begin
      @(negedge clk);
      rreg(2'd3, st);
    end
    chk(st[22] === 1'b0, "R6 pending clears", st, 32'h0);
    ok = (nrise == 8 * ne);
    for (int i = start; i < ne; i++) if (cap[i] !== expb[i]) ok = 1'b0;
    chk(ok, tag, nrise, 8 * ne);
    chk(held ? (cs_n === ~(8'd1 << cur_cs)) : (cs_n === 8'hFF), "R8/R9 chip select after command",
        {24'h0, cs_n}, held ? {24'h0, ~(8'd1 << cur_cs)} : 32'hFF);
    if (exp_rd) begin
      rreg(2'd2, dv);
      chk(dv === exp_dat, "R5 read data register", dv, exp_dat);
    end
    chk(badcs == 0 && sck === 1'b1, "R10 chip select during edges and SCK idle", badcs, 0);
  endtask

  initial begin
    logic [31:0] st, v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rreg(2'd3, st);
    chk(st === 32'h0 && sck === 1'b1 && cs_n === 8'hFF && mosi === 1'b0, "R10 reset state", st, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    issue(8'h9F, 1'b0, 3'd3, 1'b0, 4'd0, 3'd0, 3'd1, 24'h0, 32'h1122_3344);
    finish_cmd("R1/R5 opcode then read stream");
    issue(8'h02, 1'b1, 3'd4, 1'b0, 4'd2, 3'd3, 3'd6, 24'hA1B2C3, 32'hDEAD_BEEF);
    finish_cmd("R2/R3/R4 address dummy write stream");

    issue(8'h0B, 1'b1, 3'd0, 1'b1, 4'd1, 3'd3, 3'd2, 24'h123456, 32'h0);
    finish_cmd("R8 held first part");
    issue(8'hFF, 1'b0, 3'd4, 1'b1, 4'd0, 3'd0, 3'd5, 24'h0, 32'h0);
    finish_cmd("R8 continuation sends no opcode, index ignored");
    issue(8'h00, 1'b0, 3'd0, 1'b0, 4'd0, 3'd0, 3'd3, 24'h0, 32'h0);
    finish_cmd("R9 end-only command adds no edges");

    issue(8'h38, 1'b1, 3'd7, 1'b0, 4'd0, 3'd7, 3'd4, 24'h89ABCD, 32'h0506_0708);
    finish_cmd("R2/R4 clamped counts");

    issue(8'h3B, 1'b0, 3'd2, 1'b0, 4'd0, 3'd1, 3'd0, 24'h00004F, 32'hCAFE_F00D);
    finish_cmd("R5 partial read keeps upper bytes");

    issue(8'h6B, 1'b0, 3'd1, 1'b0, 4'd15, 3'd0, 3'd7, 24'h0, 32'h0);
    wreg(2'd0, mk(8'hC7, 1'b1, 3'd4, 1'b1, 4'd3, 3'd3, 3'd2));
    rreg(2'd3, st);
    chk(st[29] === 1'b1 && st[22] === 1'b1, "R7 error on write while pending", st, 32'h2040_0000);
    finish_cmd("R7 rejected command leaves wire untouched");
    rreg(2'd3, st);
    chk(st[29] === 1'b1, "R7 error sticky", st, 32'h2000_0000);
    wreg(2'd3, 32'h2000_0000);
    rreg(2'd3, st);
    chk(st === 32'h0, "R7 error cleared by write one", st, 0);
    rreg(2'd0, v);
    chk(v[7:0] === 8'h6B, "R7 command register keeps accepted command", v, 32'h6B);

    for (int n = 0; n < 40; n++) begin
      issue(8'($urandom), 1'($urandom), 3'($urandom % 5), ($urandom % 3) == 0,
            4'($urandom % 4), 3'($urandom % 4), 3'($urandom), 24'($urandom), $urandom);
      finish_cmd("R1/R2/R3/R4/R5 random command stream");
    end
    if (held) begin
      issue(8'h00, 1'b0, 3'd0, 1'b0, 4'd0, 3'd0, 3'd0, 24'h0, 32'h0);
      finish_cmd("R9 closing command");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule